// File: doc/BRIEF.md
# Memory Test Pattern Sequencer

This block drives a bit-wide dynamic memory under test through a fixed soak routine. After reset it fills every location once with a chosen pattern. It then reads the whole memory back again and again until the next reset, comparing each bit it reads with the bit the pattern says should be there. Both the fill and the reads use the same rhythm: a burst of sequential one-bit accesses, then a long interval with chip enable held off, then a refresh sweep that visits every row of the array.

Every access takes one bit period, which is a fixed number of clocks (one microsecond at the default settings). Chip enable is high for the first half of each bit period. The memory returns read data combinationally. The sequencer samples that data on the last clock of the enable half. A mismatch produces a one-cycle report that carries the address, the expected bit, the actual bit and the read pass in which it happened. The report has no ready input: the soak routine cannot pause, so a consumer must take each strobe in the cycle it appears. A saturating counter totals the errors, and a pass counter shows that re-reading goes on.

All timing figures are parameters, so a bench can shrink the routine. Defaults: 4096 locations, 64 rows, bursts of 256 bits, a gap of 1680 bit periods, 125 clocks per bit period. The row address is the low address bits, so a refresh sweep drives row r on the low ROW_W address lines with the upper lines at zero.

Top module: `memtest_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high), `mem_ce`, `mem_we`, `err_stb` and `done_wr` are 0, and `err_cnt` and `pass_cnt` are 0. The first bit period starts on the second clock edge after `rst` falls.
- R2: A bit period lasts CLK_PER_US clocks. In each access or refresh bit period, `mem_ce` is high for the first CLK_PER_US/2 clocks (rounded down) and low for the rest.
- R3: Accesses come in bursts of BURST_LEN bit periods to consecutive addresses, counting up from 0. Each burst is followed by OFF_US bit periods during which `mem_ce` stays low.
- R4: Each gap is followed by a refresh sweep of 2^ROW_W bit periods. The sweep drives rows 0, 1, ... 2^ROW_W-1 in order on the low ROW_W bits of `mem_addr`, with the upper address bits at 0 and `mem_we` low. The next burst then starts.
- R5: During the first pass over all 2^ADDR_W locations, `mem_we` is high in every burst bit period and `mem_din` carries the pattern bit for `mem_addr`. `done_wr` rises when the bit period of the last location ends. After that, `mem_we` is never high again until reset.
- R6: The pattern comes from `pat_sel`: 0 stores 1 at even addresses and 0 at odd addresses; 1 stores 0 at even and 1 at odd; 2 and 3 store 0 everywhere. `pat_sel` is taken only while `rst` is high. Later changes have no effect on writes or comparisons.
- R7: After `done_wr`, every burst bit period is a read. `mem_dout` is sampled on the last clock of the enable half. On a mismatch, `err_stb` is high for exactly the next clock, together with `err_addr`, `err_exp`, `err_act` and `err_pass` (the value `pass_cnt` had when the read was made).
- R8: `err_cnt` adds one for every mismatch and stops at 2^ERR_W-1.
- R9: `pass_cnt` adds one when the bit period of the last location in a read pass ends. Reading repeats without end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also latches `pat_sel` |
| pat_sel | input | 2 | Pattern code (see R6) |
| mem_ce | output | 1 | Chip enable to the memory under test |
| mem_we | output | 1 | Write enable to the memory under test |
| mem_addr | output | ADDR_W (12) | Location, or row during refresh |
| mem_din | output | 1 | Write data to the memory |
| mem_dout | input | 1 | Read data from the memory |
| done_wr | output | 1 | Fill pass complete |
| pass_cnt | output | PASS_W (16) | Completed read passes, saturating |
| err_stb | output | 1 | One-cycle mismatch strobe |
| err_addr | output | ADDR_W (12) | Address of the last mismatch |
| err_exp | output | 1 | Expected bit of the last mismatch |
| err_act | output | 1 | Bit read at the last mismatch |
| err_pass | output | PASS_W (16) | Read pass index of the last mismatch |
| err_cnt | output | ERR_W (16) | Saturating mismatch count |

## Verification
The bench models the memory, with one optional stuck-high location or every location stuck high. It runs each pattern code against a stuck cell at an even and at an odd address. A stuck cell that agrees with the pattern must stay silent, and one that disagrees must be reported once per pass; this tells apart the two alternating patterns, the all-zero codes, and correct address reporting. The memory starts out holding the inverse of the pattern, so a missing write shows up as errors. Changing the pattern code after the fill must leave a clean memory error-free. A memory that is stuck everywhere drives the counter into saturation. The access, gap and refresh waveform is also compared cycle by cycle with a timing model for the first two bursts.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [1:0] {
    SEG_BURST = 2'd0,
    SEG_GAP   = 2'd1,
    SEG_RFSH  = 2'd2
  } seg_e;

  localparam logic [1:0] PAT_ONEZERO = 2'd0;
  localparam logic [1:0] PAT_ZEROONE = 2'd1;

  // Pattern bit stored at a location, chosen by its address parity.
  function automatic logic pat_bit(input logic [1:0] pat, input logic lsb);
    case (pat)
      PAT_ONEZERO: return ~lsb;
      PAT_ZEROONE: return lsb;
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/memtest_tick.sv
module memtest_tick #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst,
  output logic run,
  output logic on,
  output logic smp,
  output logic last
);
  localparam int HALF = CLK_PER_US / 2;
  localparam int PH_W = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_US - 1);
  localparam logic [PH_W-1:0] PH_SMP  = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);

  logic [PH_W-1:0] ph_q;
  logic            run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ph_q  <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        if (ph_q == PH_LAST) ph_q <= '0;
        else                 ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign run  = run_q;
  assign on   = run_q && (ph_q < PH_HALF);
  assign smp  = run_q && (ph_q == PH_SMP);
  assign last = run_q && (ph_q == PH_LAST);

  // R2
  half_end_chk: assert property (@(posedge clk) disable iff (rst)
    smp |=> !on);

  // R2
  period_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    last |=> on);

endmodule

// File: rtl/memtest_sched.sv
module memtest_sched
  import memtest_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ROW_W     = 6,
  parameter int BURST_LEN = 256,
  parameter int OFF_US    = 1680,
  parameter int PASS_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last,
  output seg_e              seg,
  output logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic              done_wr,
  output logic [PASS_W-1:0] pass_cnt
);
  localparam int ROWS   = 1 << ROW_W;
  localparam int MAX_BO = (BURST_LEN > OFF_US) ? BURST_LEN : OFF_US;
  localparam int MAXN   = (MAX_BO > ROWS) ? MAX_BO : ROWS;
  localparam int STEP_W = (MAXN > 2) ? $clog2(MAXN) : 1;
  localparam logic [STEP_W-1:0] BURST_END = STEP_W'(BURST_LEN - 1);
  localparam logic [STEP_W-1:0] GAP_END   = STEP_W'(OFF_US - 1);
  localparam logic [STEP_W-1:0] RFSH_END  = STEP_W'(ROWS - 1);
  localparam logic [PASS_W-1:0] PASS_MAX  = '1;

  seg_e              seg_q;
  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic [PASS_W-1:0] pass_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= SEG_BURST;
      step_q <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      pass_q <= '0;
    end else if (last) begin
      case (seg_q)
        SEG_BURST: begin
          addr_q <= addr_q + 1'b1;
          if (&addr_q) begin
            if (!done_q)                done_q <= 1'b1;
            else if (pass_q != PASS_MAX) pass_q <= pass_q + 1'b1;
          end
          if (step_q == BURST_END) begin
            step_q <= '0;
            seg_q  <= SEG_GAP;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        SEG_GAP: begin
          if (step_q == GAP_END) begin
            step_q <= '0;
            seg_q  <= SEG_RFSH;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: begin
          if (step_q == RFSH_END) begin
            step_q <= '0;
            seg_q  <= SEG_BURST;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign seg      = seg_q;
  assign addr     = addr_q;
  assign row      = step_q[ROW_W-1:0];
  assign done_wr  = done_q;
  assign pass_cnt = pass_q;

  // R3
  gap_order_chk: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_GAP) |=> (seg_q != SEG_BURST));

  // R9
  pass_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_q != $past(pass_q)) |-> done_q);

endmodule

// File: rtl/memtest_check.sv
module memtest_check
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ERR_W  = 16,
  parameter int PASS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pat_sel,
  input  logic              smp,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dout,
  input  logic [PASS_W-1:0] pass_cnt,
  output logic              exp_bit,
  output logic              err_stb,
  output logic [ADDR_W-1:0] err_addr,
  output logic              err_exp,
  output logic              err_act,
  output logic [PASS_W-1:0] err_pass,
  output logic [ERR_W-1:0]  err_cnt
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [1:0]        pat_q;
  logic              stb_q;
  logic [ADDR_W-1:0] eaddr_q;
  logic              eexp_q;
  logic              eact_q;
  logic [PASS_W-1:0] epass_q;
  logic [ERR_W-1:0]  cnt_q;

  // Pattern code is only taken while reset is held.
  always_ff @(posedge clk) begin
    if (rst) pat_q <= pat_sel;
  end

  assign exp_bit = pat_bit(pat_q, addr[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q   <= 1'b0;
      eaddr_q <= '0;
      eexp_q  <= 1'b0;
      eact_q  <= 1'b0;
      epass_q <= '0;
      cnt_q   <= '0;
    end else begin
      stb_q <= 1'b0;
      if (smp && rd_en && (dout != exp_bit)) begin
        stb_q   <= 1'b1;
        eaddr_q <= addr;
        eexp_q  <= exp_bit;
        eact_q  <= dout;
        epass_q <= pass_cnt;
        if (cnt_q != ERR_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign err_stb  = stb_q;
  assign err_addr = eaddr_q;
  assign err_exp  = eexp_q;
  assign err_act  = eact_q;
  assign err_pass = epass_q;
  assign err_cnt  = cnt_q;

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stb_q |=> !stb_q);

  // R8
  err_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cnt_q >= $past(cnt_q)));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == ERR_MAX) |=> (cnt_q == ERR_MAX));

  // R6
  pat_latch_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(pat_q));

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int ROW_W      = 6,
  parameter int BURST_LEN  = 256,
  parameter int OFF_US     = 1680,
  parameter int CLK_PER_US = 125,
  parameter int ERR_W      = 16,
  parameter int PASS_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pat_sel,
  output logic              mem_ce,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_din,
  input  logic              mem_dout,
  output logic              done_wr,
  output logic [PASS_W-1:0] pass_cnt,
  output logic              err_stb,
  output logic [ADDR_W-1:0] err_addr,
  output logic              err_exp,
  output logic              err_act,
  output logic [PASS_W-1:0] err_pass,
  output logic [ERR_W-1:0]  err_cnt
);
  localparam int HI_W = ADDR_W - ROW_W;

  logic              run, on, smp, last;
  seg_e              seg;
  logic [ADDR_W-1:0] loc;
  logic [ROW_W-1:0]  row;
  logic              exp_bit;
  logic              rd_en;

  memtest_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .run(run), .on(on), .smp(smp), .last(last)
  );

  memtest_sched #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .BURST_LEN(BURST_LEN),
    .OFF_US(OFF_US), .PASS_W(PASS_W)
  ) u_sched (
    .clk(clk), .rst(rst), .last(last), .seg(seg), .addr(loc), .row(row),
    .done_wr(done_wr), .pass_cnt(pass_cnt)
  );

  assign rd_en = (seg == SEG_BURST) && done_wr;

  memtest_check #(.ADDR_W(ADDR_W), .ERR_W(ERR_W), .PASS_W(PASS_W)) u_check (
    .clk(clk), .rst(rst), .pat_sel(pat_sel), .smp(smp), .rd_en(rd_en),
    .addr(loc), .dout(mem_dout), .pass_cnt(pass_cnt), .exp_bit(exp_bit),
    .err_stb(err_stb), .err_addr(err_addr), .err_exp(err_exp),
    .err_act(err_act), .err_pass(err_pass), .err_cnt(err_cnt)
  );

  assign mem_ce   = on && (seg != SEG_GAP);
  assign mem_we   = run && (seg == SEG_BURST) && !done_wr;
  assign mem_addr = (seg == SEG_RFSH) ? {{HI_W{1'b0}}, row} : loc;
  assign mem_din  = exp_bit;

  // R5
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_wr |-> !mem_we);

  // R4
  rfsh_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_RFSH) |-> (!mem_we && (mem_addr[ADDR_W-1:ROW_W] == '0)));

endmodule

// File: tb/memtest_seq_tb.sv
module memtest_seq_tb;
  localparam int AW = 8, RW = 4, BL = 16, OFFN = 3, CPU = 4, EW = 6, PW = 16;
  localparam int DEPTH = 1 << AW, ROWS = 1 << RW, HALF = CPU / 2;
  localparam int T_BURST = BL * CPU, T_GAP = OFFN * CPU, T_RF = ROWS * CPU;
  localparam int T_SLOT = T_BURST + T_GAP + T_RF;
  localparam int EMAX = (1 << EW) - 1;

  typedef struct packed {
    logic [1:0]    pat;
    logic          st_en;
    logic          st_all;
    logic [AW-1:0] st_addr;
    logic [8:0]    per_pass;
  } vec_t;

  // pattern, stuck enable, all stuck, stuck address, mismatches per pass
  localparam vec_t VECS [7] = '{
    '{2'd0, 1'b1, 1'b0, 8'd5,   9'd1},
    '{2'd0, 1'b1, 1'b0, 8'd4,   9'd0},
    '{2'd1, 1'b1, 1'b0, 8'd4,   9'd1},
    '{2'd1, 1'b1, 1'b0, 8'd5,   9'd0},
    '{2'd2, 1'b1, 1'b0, 8'd200, 9'd1},
    '{2'd3, 1'b1, 1'b0, 8'd7,   9'd1},
    '{2'd0, 1'b0, 1'b0, 8'd0,   9'd0}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [1:0]    pat_sel = 2'd0;
  logic          mem_ce, mem_we, mem_din, mem_dout;
  logic [AW-1:0] mem_addr;
  logic          done_wr, err_stb, err_exp, err_act;
  logic [PW-1:0] pass_cnt, err_pass;
  logic [AW-1:0] err_addr;
  logic [EW-1:0] err_cnt;

  memtest_seq #(
    .ADDR_W(AW), .ROW_W(RW), .BURST_LEN(BL), .OFF_US(OFFN),
    .CLK_PER_US(CPU), .ERR_W(EW), .PASS_W(PW)
  ) u_dut (
    .clk(clk), .rst(rst), .pat_sel(pat_sel), .mem_ce(mem_ce), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_din(mem_din), .mem_dout(mem_dout),
    .done_wr(done_wr), .pass_cnt(pass_cnt), .err_stb(err_stb),
    .err_addr(err_addr), .err_exp(err_exp), .err_act(err_act),
    .err_pass(err_pass), .err_cnt(err_cnt)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  function automatic logic expb(input logic [1:0] p, input int a);
    case (p)
      2'd0:    return ~a[0];
      2'd1:    return a[0];
      default: return 1'b0;
    endcase
  endfunction

  // Behavioural memory: filled with the inverse pattern during reset.
  logic          mem [DEPTH];
  logic [1:0]    init_pat = 2'd0;
  logic          st_en = 1'b0, st_all = 1'b0;
  logic [AW-1:0] st_addr = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ~expb(init_pat, i);
    end else if (mem_ce && mem_we) begin
      mem[mem_addr] <= mem_din;
    end
  end

  assign mem_dout = (st_all || (st_en && mem_addr == st_addr)) ? 1'b1 : mem[mem_addr];

  // Monitor of strobes and write cycles.
  int            n_stb, n_wr;
  logic [AW-1:0] l_addr;
  logic          l_exp, l_act;
  logic [PW-1:0] l_pass;

  always @(negedge clk) begin
    if (rst) begin
      n_stb <= 0;
      n_wr  <= 0;
    end else begin
      if (err_stb) begin
        n_stb  <= n_stb + 1;
        l_addr <= err_addr;
        l_exp  <= err_exp;
        l_act  <= err_act;
        l_pass <= err_pass;
      end
      if (mem_ce && mem_we) n_wr <= n_wr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] p, input logic en, input logic all,
                          input logic [AW-1:0] a);
    rst = 1'b1;
    pat_sel = p;
    init_pat = p;
    st_en = en;
    st_all = all;
    st_addr = a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_pass(input int n);
    while (int'(pass_cnt) < n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e_ce_bad, e_burst_bad, e_rf_bad, e_wr_bad;
    int wr_at_done;

    // Reset state, R1
    rst = 1'b1;
    pat_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk(mem_ce == 1'b0 && mem_we == 1'b0, "R1", "ce/we in reset", {mem_ce, mem_we}, 0);
    chk(err_stb == 1'b0 && done_wr == 1'b0, "R1", "stb/done in reset", {err_stb, done_wr}, 0);
    chk(err_cnt == '0 && pass_cnt == '0, "R1", "counters in reset", int'(err_cnt) + int'(pass_cnt), 0);

    // Waveform of the first two burst slots against a timing model
    e_ce_bad = 0; e_burst_bad = 0; e_rf_bad = 0; e_wr_bad = 0;
    rst = 1'b0;
    for (int i = 0; i < 2 * T_SLOT; i++) begin
      int k, b, r;
      logic e_ce;
      @(negedge clk);
      k = i % T_SLOT;
      b = i / T_SLOT;
      if (k < T_BURST) begin
        e_ce = ((k % CPU) < HALF);
        if (e_ce && mem_addr != AW'(b * BL + k / CPU)) e_burst_bad++;
        if (!mem_we || mem_din != expb(2'd0, b * BL + k / CPU)) e_wr_bad++;
      end else if (k < T_BURST + T_GAP) begin
        e_ce = 1'b0;
        if (mem_ce) e_burst_bad++;
      end else begin
        r = k - T_BURST - T_GAP;
        e_ce = ((r % CPU) < HALF);
        if (mem_we || (e_ce && mem_addr != AW'(r / CPU))) e_rf_bad++;
      end
      if (mem_ce != e_ce) e_ce_bad++;
    end
    chk(e_ce_bad == 0, "R2", "ce duty mismatches", e_ce_bad, 0);
    chk(e_burst_bad == 0, "R3", "burst/gap mismatches", e_burst_bad, 0);
    chk(e_rf_bad == 0, "R4", "refresh mismatches", e_rf_bad, 0);
    chk(e_wr_bad == 0, "R5", "write enable/data mismatches", e_wr_bad, 0);

    while (!done_wr) @(negedge clk);
    wr_at_done = n_wr;
    chk(wr_at_done == DEPTH * HALF, "R5", "write cycles in fill", wr_at_done, DEPTH * HALF);
    wait_pass(1);
    chk(n_wr == wr_at_done, "R5", "write cycles after fill", n_wr, wr_at_done);
    chk(err_cnt == '0, "R7", "errors on clean memory", int'(err_cnt), 0);
    chk(pass_cnt == PW'(1), "R9", "pass count", int'(pass_cnt), 1);

    // Vector table: pattern against stuck-high cells
    for (int v = 0; v < 7; v++) begin
      vec_t t;
      t = VECS[v];
      do_reset(t.pat, t.st_en, t.st_all, t.st_addr);
      wait_pass(2);
      chk(int'(err_cnt) == 2 * int'(t.per_pass), "R6 R7", "error count", int'(err_cnt), 2 * int'(t.per_pass));
      chk(n_stb == 2 * int'(t.per_pass), "R7", "strobe count", n_stb, 2 * int'(t.per_pass));
      if (t.per_pass != 0) begin
        chk(l_addr == t.st_addr, "R7", "error address", int'(l_addr), int'(t.st_addr));
        chk(l_exp == 1'b0 && l_act == 1'b1, "R7", "expected/actual bits", {l_exp, l_act}, 1);
        chk(l_pass == PW'(1), "R7", "error pass index", int'(l_pass), 1);
      end
    end

    // Pattern code changed after the fill must be ignored, R6
    do_reset(2'd0, 1'b0, 1'b0, '0);
    while (!done_wr) @(negedge clk);
    pat_sel = 2'd1;
    wait_pass(1);
    chk(err_cnt == '0, "R6", "errors after late pattern change", int'(err_cnt), 0);
    chk(n_stb == 0, "R6", "strobes after late pattern change", n_stb, 0);

    // Every cell stuck high with all-zero pattern: saturation, R8
    do_reset(2'd2, 1'b0, 1'b1, '0);
    wait_pass(1);
    chk(int'(err_cnt) == EMAX, "R8", "saturated count", int'(err_cnt), EMAX);
    chk(n_stb == DEPTH, "R7", "one strobe per mismatch", n_stb, DEPTH);
    wait_pass(3);
    chk(int'(err_cnt) == EMAX, "R8", "count held at limit", int'(err_cnt), EMAX);
    chk(pass_cnt == PW'(3), "R9", "re-read passes", int'(pass_cnt), 3);
    chk(l_pass == PW'(2), "R7", "last error pass index", int'(l_pass), 2);
    chk(n_stb == 3 * DEPTH, "R9", "strobes over three passes", n_stb, 3 * DEPTH);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule